// File: doc/BRIEF.md
# Descriptor-Framed Display Serial Transmitter

This block drives a write-only serial display link from a stream of 32-bit words. The first word of each transfer is a control descriptor. It gives the number of bytes to send, whether those bytes are a display command or display data, a unit size of 1, 2 or 4 bytes that controls optional lane swapping, and whether a completion pulse is wanted. The words that follow carry the payload, four bytes per word. A final word that is only partly filled carries its bytes in its low lanes.

The link has one active-low select and one serial clock with a configurable idle level and sampling edge. It can run in two modes. In the three-line mode, each byte goes out as a 9-bit frame whose leading bit is the command/data flag. In the four-line mode, bytes are 8 bits long and a separate data/command line carries the flag. Bit order within a byte can be selected. When the word source runs dry in the middle of a transfer, the link pauses with the select held low and resumes when words arrive. The half period of the serial clock is a parameter counted in system clocks.

Top module: `dbi_spi_tx`

## Requirements
- R1: A transmit descriptor sends exactly (bits [17:0] + 1) bytes. The select line then returns high, and that transfer draws no further words.
- R2: A descriptor with bit 31 = 0 (receive direction) is consumed from the word source. It produces no select activity and no completion pulse, and the next descriptor is handled normally.
- R3: The one-cycle `done_o` pulse appears exactly one clock after `cs_no` rises, and only when descriptor bit 29 was 1.
- R4: Payload bytes leave in lane order 0,1,2,3 of each word, where lane k is bits [8k+7:8k]. A final word that holds m = 1..3 bytes supplies only lanes 0..m-1.
- R5: With `cfg_swap_i` = 1, a full word is sent with its lane index XOR-ed by a mask taken from descriptor bits [28:27]: 0 (byte) gives mask 0, 1 (halfword) gives mask 1, 2 (word) gives mask 3, and the unused code 3 gives mask 0. A final partial word is never swapped.
- R6: In three-line mode (`cfg_four_wire_i` = 0), every byte is a 9-bit frame whose first bit is descriptor bit 30 (1 = data), and `dc_o` stays low.
- R7: In four-line mode, frames are 8 bits and `dc_o` equals descriptor bit 30 and stays stable while `cs_no` is low.
- R8: While `cs_no` is high, `sck_o` rests at `cfg_cpol_i`. The bit on `sdo_o` is sampled on the edge that moves `sck_o` to `cfg_cpol_i` XOR NOT `cfg_cpha_i`. Each bit lasts 2*HALF_DIV clocks.
- R9: `cfg_lsb_first_i` = 0 sends each byte MSB first, and 1 sends it LSB first. The three-line flag bit always leads the frame.
- R10: If no word is available when the next byte is due, `sck_o` freezes and `cs_no` stays low until a word arrives.
- R11: Descriptor bits [20:18], 23, [25:24] and 26 have no effect on anything seen on the link.
- R12: During reset `cs_no` is 1, `done_o` is 0 and `fifo_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_four_wire_i | input | 1 | 1 = separate data/command line, 0 = 9-bit frames |
| cfg_cpol_i | input | 1 | Idle level of the serial clock |
| cfg_cpha_i | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_lsb_first_i | input | 1 | Bit order within a byte |
| cfg_swap_i | input | 1 | Enable lane swapping by unit size |
| fifo_data_i | input | 32 | Word from the transmit source |
| fifo_valid_i | input | 1 | Word available |
| fifo_ready_o | output | 1 | Word accepted this cycle when valid |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Active-low select |
| dc_o | output | 1 | Data/command line (four-line mode) |
| sdo_o | output | 1 | Serial data out |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps all sixteen combinations of link mode, clock polarity, clock phase and bit order. It also sweeps every unit-size code, with swap on and off, over byte counts of 1 to 9, so that every partial final word is reached. A design that swaps a partial word, or takes a wrong lane, sends a byte from the wrong lane. One that is off by one on the count sends one frame too many or too few. A descriptor that sets every ignored field must produce the same link traffic as a plain one. A receive-direction descriptor must vanish without any select or completion activity. A deliberate source stall must freeze the clock with the select held low, which catches a design that lets the clock run on. The position of the completion pulse is measured against the select release, which catches a pulse that arrives early or late or is not gated by the descriptor.

// File: rtl/dbi_tx_pkg.sv
`timescale 1ns/1ps
package dbi_tx_pkg;
  localparam int unsigned LEN_W  = 18;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned NB_W   = LANE_W + 1;

  typedef enum logic [1:0] {
    FMT_BYTE = 2'd0,
    FMT_HALF = 2'd1,
    FMT_WORD = 2'd2,
    FMT_RSVD = 2'd3
  } unit_fmt_e;

  typedef struct packed {
    logic             is_tx;
    logic             is_data;
    logic             done_en;
    unit_fmt_e        fmt;
    logic             tmo_mode;
    logic [1:0]       sync_mode;
    logic             rpt_en;
    logic [1:0]       spare;
    logic [2:0]       gap_clks;
    logic [LEN_W-1:0] len_m1;
  } xfer_desc_t;

  function automatic logic [LANE_W-1:0] lane_mask(unit_fmt_e f);
    case (f)
      FMT_HALF: lane_mask = LANE_W'(1);
      FMT_WORD: lane_mask = LANE_W'(3);
      default:  lane_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/dbi_tx_unpack.sv
`timescale 1ns/1ps
module dbi_tx_unpack
  import dbi_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [NB_W-1:0]   nbytes_i,
  input  logic [LANE_W-1:0] mask_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [7:0]        byte_o
);
  logic [WORD_W-1:0] word_q;
  logic [NB_W-1:0]   nb_q;
  logic [LANE_W-1:0] mask_q, idx_q, lane;
  logic              full_q, last;

  // partial final word keeps natural lane order
  assign lane    = (nb_q == NB_W'(LANES)) ? (idx_q ^ mask_q) : idx_q;
  assign byte_o  = word_q[{lane, 3'b000} +: 8];
  assign last    = ({1'b0, idx_q} == (nb_q - NB_W'(1)));
  assign valid_o = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      nb_q   <= '0;
      mask_q <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (load_i) begin
      word_q <= word_i;
      nb_q   <= nbytes_i;
      mask_q <= mask_i;
      idx_q  <= '0;
      full_q <= 1'b1;
    end else if (take_i) begin
      if (last) full_q <= 1'b0;
      else      idx_q  <= idx_q + LANE_W'(1);
    end
  end

  // R4
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !full_q);
  // R4
  take_has_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q);
  // R4
  nb_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (nbytes_i != '0 && nbytes_i <= NB_W'(LANES)));
endmodule

// File: rtl/dbi_tx_serdes.sv
`timescale 1ns/1ps
module dbi_tx_serdes #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       dc_i,
  input  logic       nine_i,
  input  logic       lsb_i,
  output logic       take_o,
  output logic       busy_o,
  output logic       half_o,
  output logic       bit_o
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned FRM_W = 9;

  logic [CNT_W-1:0] cnt_q;
  logic             half_q, busy_q, end_half, byte_end;
  logic [3:0]       bits_q;
  logic [FRM_W-1:0] sreg_q, frame;
  logic [7:0]       ordered;

  always_comb begin
    for (int b = 0; b < 8; b++) ordered[b] = lsb_i ? byte_i[7-b] : byte_i[b];
  end

  assign frame    = nine_i ? {dc_i, ordered} : {ordered, 1'b0};
  assign end_half = (cnt_q == CNT_W'(HALF_DIV - 1));
  assign byte_end = busy_q && half_q && end_half && (bits_q == 4'd1);
  assign take_o   = go_i && byte_valid_i && (!busy_q || byte_end);
  assign busy_o   = busy_q;
  assign half_o   = half_q;
  assign bit_o    = sreg_q[FRM_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      busy_q <= 1'b0;
      bits_q <= '0;
      sreg_q <= '0;
    end else if (take_o) begin
      sreg_q <= frame;
      bits_q <= nine_i ? 4'd9 : 4'd8;
      busy_q <= 1'b1;
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (end_half) begin
        cnt_q <= '0;
        if (half_q) begin
          half_q <= 1'b0;
          bits_q <= bits_q - 4'd1;
          sreg_q <= {sreg_q[FRM_W-2:0], 1'b0};
          if (bits_q == 4'd1) busy_q <= 1'b0;
        end else begin
          half_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R6
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (bits_q != 4'd0 && bits_q <= 4'd9));
  // R8
  half_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !end_half && !take_o) |=> $stable(half_q));
endmodule

// File: rtl/dbi_spi_tx.sv
`timescale 1ns/1ps
module dbi_spi_tx
  import dbi_tx_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_four_wire_i,
  input  logic              cfg_cpol_i,
  input  logic              cfg_cpha_i,
  input  logic              cfg_lsb_first_i,
  input  logic              cfg_swap_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  input  logic              fifo_valid_i,
  output logic              fifo_ready_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              dc_o,
  output logic              sdo_o,
  output logic              done_o
);
  localparam int unsigned GAP_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned CNT_W = LEN_W + 1;

  typedef enum logic [2:0] {
    T_IDLE, T_LEAD, T_RUN, T_TAIL, T_REL, T_DONE
  } tx_state_e;

  tx_state_e   state_q;
  xfer_desc_t  desc;
  logic        data_q, done_en_q;
  unit_fmt_e   fmt_q;
  logic [CNT_W-1:0] bytes_left_q, load_left_q;
  logic [GAP_W-1:0] gap_q;
  logic        gap_end, cs_act, want_word, unp_load;
  logic [NB_W-1:0] nbytes;
  logic        unp_valid, ser_take, ser_busy, ser_half, ser_bit;
  logic [7:0]  unp_byte;
  logic        cs_n_q, sck_q, sdo_q, dc_q, done_q;
  logic        unused_desc_bits;

  assign desc = xfer_desc_t'(fifo_data_i);
  assign unused_desc_bits = ^{desc.tmo_mode, desc.sync_mode, desc.rpt_en,
                              desc.spare, desc.gap_clks};

  assign gap_end   = (gap_q == GAP_W'(HALF_DIV - 1));
  assign cs_act    = (state_q == T_LEAD) || (state_q == T_RUN) || (state_q == T_TAIL);
  assign want_word = (state_q == T_RUN) && !unp_valid && (load_left_q != '0);
  assign fifo_ready_o = (state_q == T_IDLE) || want_word;
  assign unp_load  = want_word && fifo_valid_i;
  assign nbytes    = (load_left_q >= CNT_W'(LANES)) ? NB_W'(LANES)
                                                    : NB_W'(load_left_q);

  dbi_tx_unpack i_unpack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (unp_load),
    .word_i   (fifo_data_i),
    .nbytes_i (nbytes),
    .mask_i   (cfg_swap_i ? lane_mask(fmt_q) : '0),
    .take_i   (ser_take),
    .valid_o  (unp_valid),
    .byte_o   (unp_byte)
  );

  dbi_tx_serdes #(.HALF_DIV(HALF_DIV)) i_serdes (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (state_q == T_RUN),
    .byte_valid_i (unp_valid),
    .byte_i       (unp_byte),
    .dc_i         (data_q),
    .nine_i       (!cfg_four_wire_i),
    .lsb_i        (cfg_lsb_first_i),
    .take_o       (ser_take),
    .busy_o       (ser_busy),
    .half_o       (ser_half),
    .bit_o        (ser_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= T_IDLE;
      data_q       <= 1'b0;
      done_en_q    <= 1'b0;
      fmt_q        <= FMT_BYTE;
      bytes_left_q <= '0;
      load_left_q  <= '0;
      gap_q        <= '0;
    end else begin
      if (unp_load) load_left_q <= load_left_q - CNT_W'(nbytes);
      if (ser_take) bytes_left_q <= bytes_left_q - CNT_W'(1);
      case (state_q)
        T_IDLE: if (fifo_valid_i && desc.is_tx) begin
          state_q      <= T_LEAD;
          data_q       <= desc.is_data;
          done_en_q    <= desc.done_en;
          fmt_q        <= desc.fmt;
          bytes_left_q <= {1'b0, desc.len_m1} + CNT_W'(1);
          load_left_q  <= {1'b0, desc.len_m1} + CNT_W'(1);
          gap_q        <= '0;
        end
        T_LEAD: begin
          gap_q <= gap_q + GAP_W'(1);
          if (gap_end) begin
            gap_q   <= '0;
            state_q <= T_RUN;
          end
        end
        T_RUN: if (bytes_left_q == '0 && !ser_busy) state_q <= T_TAIL;
        T_TAIL: begin
          gap_q <= gap_q + GAP_W'(1);
          if (gap_end) begin
            gap_q   <= '0;
            state_q <= T_REL;
          end
        end
        T_REL:   state_q <= T_DONE;
        default: state_q <= T_IDLE;
      endcase
    end
  end

  // link outputs, one register stage behind the engine
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q <= 1'b1;
      sck_q  <= 1'b0;
      sdo_q  <= 1'b0;
      dc_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cs_n_q <= !cs_act;
      if (!cs_act)       sck_q <= cfg_cpol_i;
      else if (ser_busy) sck_q <= cfg_cpol_i ^ cfg_cpha_i ^ ser_half;
      if (!cs_act)       sdo_q <= 1'b0;
      else if (ser_busy) sdo_q <= ser_bit;
      dc_q   <= cs_act && cfg_four_wire_i && data_q;
      done_q <= (state_q == T_DONE) && done_en_q;
    end
  end

  assign cs_no  = cs_n_q;
  assign sck_o  = sck_q;
  assign sdo_o  = sdo_q;
  assign dc_o   = dc_q;
  assign done_o = done_q;

  // R1
  count_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_take |-> bytes_left_q != '0);
  // R1
  release_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> bytes_left_q == '0);
  // R3
  done_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && $past(cs_no)));
  // R3
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  dc_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no) && $stable(cfg_four_wire_i)) |-> $stable(dc_o));
  // R10
  stall_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state_q == T_RUN && !ser_busy) |-> ($stable(sck_o) && !cs_no));
endmodule

// File: tb/test_dbi_spi_tx.sv
`timescale 1ns/1ps
module test_dbi_spi_tx;
  localparam int HALF_DIV = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_four_wire_i = 1'b1, cfg_cpol_i = 1'b0, cfg_cpha_i = 1'b0;
  logic cfg_lsb_first_i = 1'b0, cfg_swap_i = 1'b0;
  logic [31:0] fifo_data_i = '0;
  logic fifo_valid_i = 1'b0;
  logic fifo_ready_o, sck_o, cs_no, dc_o, sdo_o, done_o;

  always #10 clk = ~clk;

  dbi_spi_tx #(.HALF_DIV(HALF_DIV)) i_dbi_spi_tx (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_four_wire_i(cfg_four_wire_i), .cfg_cpol_i(cfg_cpol_i),
    .cfg_cpha_i(cfg_cpha_i), .cfg_lsb_first_i(cfg_lsb_first_i),
    .cfg_swap_i(cfg_swap_i), .fifo_data_i(fifo_data_i),
    .fifo_valid_i(fifo_valid_i), .fifo_ready_o(fifo_ready_o),
    .sck_o(sck_o), .cs_no(cs_no), .dc_o(dc_o), .sdo_o(sdo_o), .done_o(done_o)
  );

  int checks = 0, fails = 0, cyc = 0, seed = 0;
  logic [31:0] q[$];
  logic pend = 1'b0;
  logic [31:0] wbuf[0:31];

  // monitor state
  int rx_cnt = 0, bitcnt = 0, cs_fall_cnt = 0, cs_rise_cyc = -10;
  int done_cnt = 0, done_bad = 0, edge_cnt = 0, dc_var = 0;
  bit xfer_end = 1'b0;
  logic [8:0] acc = '0;
  logic [8:0] rx_frame[0:63];
  logic rx_dcl[0:63];
  logic first_dc = 1'b0, prev_sck = 1'b0, prev_cs = 1'b1;

  // word source
  always @(negedge clk) begin
    if (pend) void'(q.pop_front());
    fifo_valid_i = (q.size() != 0);
    fifo_data_i  = fifo_valid_i ? q[0] : 32'h0;
    pend = fifo_valid_i && fifo_ready_o;
  end

  // link monitor
  always @(negedge clk) begin
    cyc++;
    if (cs_no === 1'b0 && prev_cs === 1'b1) cs_fall_cnt++;
    if (cs_no === 1'b1 && prev_cs === 1'b0) begin
      cs_rise_cyc = cyc;
      xfer_end = 1'b1;
    end
    if (cs_no === 1'b0 && sck_o !== prev_sck) begin
      edge_cnt++;
      if (sck_o == (cfg_cpol_i ^ !cfg_cpha_i)) begin
        acc = {acc[7:0], sdo_o};
        if (bitcnt == 0) first_dc = dc_o;
        else if (dc_o != first_dc) dc_var++;
        bitcnt++;
        if (bitcnt == (cfg_four_wire_i ? 8 : 9)) begin
          if (rx_cnt < 64) begin
            rx_frame[rx_cnt] = acc;
            rx_dcl[rx_cnt]   = first_dc;
          end
          rx_cnt++;
          bitcnt = 0;
          acc = '0;
        end
      end
    end
    if (done_o === 1'b1) begin
      done_cnt++;
      if (cyc != cs_rise_cyc + 1) done_bad++;
    end
    prev_sck = sck_o;
    prev_cs  = cs_no;
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      fails++;
      $display("FAIL R1 watchdog: cycles=%0d expected<=190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int k);
    repeat (k) @(posedge clk);
    #5;
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [7:0] exp_byte(input int i, input int n,
                                          input int fmt, input bit swap);
    int w, j, nb, m, lane;
    w = i / 4; j = i % 4;
    nb = (n - 4*w >= 4) ? 4 : n - 4*w;
    m = (fmt == 1) ? 1 : (fmt == 2) ? 3 : 0;
    lane = (swap && nb == 4) ? (j ^ m) : j;
    return wbuf[w][8*lane +: 8];
  endfunction

  task automatic clear_mon();
    rx_cnt = 0; bitcnt = 0; acc = '0; cs_fall_cnt = 0; done_cnt = 0;
    done_bad = 0; dc_var = 0; xfer_end = 1'b0;
  endtask

  task automatic run(input int n, input int fmt, input bit dcb, input bit irq,
                     input bit ign, input bit stall, input string tag);
    logic [31:0] desc;
    int nw, e0, waited;
    logic [7:0] got;
    seed++;
    nw = (n + 3) / 4;
    for (int k = 0; k < nw; k++)
      wbuf[k] = (32'h9E3779B9 * 32'(seed * 16 + k + 1)) ^ 32'hC3A5_5A3C;
    desc = {1'b1, dcb, irq, 2'(fmt), ign, {2{ign}}, ign, 2'b00, {3{ign}},
            18'(n - 1)};
    clear_mon();
    q.push_back(desc);
    if (stall) begin
      q.push_back(wbuf[0]);
      tick(400);
      e0 = edge_cnt;
      tick(100);
      chk(edge_cnt == e0, "R10 clock frozen during stall", 32'(edge_cnt - e0), 0);
      chk(cs_no == 1'b0, "R10 select held during stall", 32'(cs_no), 0);
      for (int k = 1; k < nw; k++) q.push_back(wbuf[k]);
    end else begin
      for (int k = 0; k < nw; k++) q.push_back(wbuf[k]);
    end
    waited = 0;
    while (!xfer_end && waited < 20000) begin
      tick(1);
      waited++;
    end
    tick(4);
    chk(rx_cnt == n, {tag, " R1 frame count"}, 32'(rx_cnt), 32'(n));
    chk(q.size() == 0, "R1 all words drawn", 32'(q.size()), 0);
    for (int i = 0; i < n && i < rx_cnt && i < 64; i++) begin
      got = cfg_lsb_first_i ? rev8(rx_frame[i][7:0]) : rx_frame[i][7:0];
      chk(got == exp_byte(i, n, fmt, cfg_swap_i),
          {tag, " R4 R5 R9 byte value"}, 32'(got),
          32'(exp_byte(i, n, fmt, cfg_swap_i)));
      if (cfg_four_wire_i)
        chk(rx_dcl[i] == dcb, "R7 dc line level", 32'(rx_dcl[i]), 32'(dcb));
      else
        chk(rx_frame[i][8] == dcb && rx_dcl[i] == 1'b0, "R6 lead flag bit",
            {rx_dcl[i], rx_frame[i]}, 32'(dcb));
    end
    chk(dc_var == 0, "R7 dc stable in transfer", 32'(dc_var), 0);
    chk(done_cnt == (irq ? 1 : 0) && done_bad == 0, "R3 completion pulse",
        32'(done_cnt * 16 + done_bad), 32'(irq ? 16 : 0));
    chk(sck_o == cfg_cpol_i, "R8 idle clock level", 32'(sck_o), 32'(cfg_cpol_i));
  endtask

  initial begin
    tick(3);
    chk(cs_no == 1'b1, "R12 reset select", 32'(cs_no), 1);
    chk(done_o == 1'b0, "R12 reset done", 32'(done_o), 0);
    chk(fifo_ready_o == 1'b1, "R12 reset ready", 32'(fifo_ready_o), 1);
    rst_ni = 1'b1;
    tick(3);

    // link modes: four-line, polarity, phase, bit order
    for (int c = 0; c < 16; c++) begin
      cfg_four_wire_i = c[0];
      cfg_cpol_i      = c[1];
      cfg_cpha_i      = c[2];
      cfg_lsb_first_i = c[3];
      cfg_swap_i      = c[1];
      tick(3);
      run(6, c % 3, c[2], 1'b1, 1'b0, 1'b0, "R8 R9");
    end

    // unit size and swap sweep over lengths covering partial words
    cfg_four_wire_i = 1'b1; cfg_cpol_i = 1'b0; cfg_cpha_i = 1'b1;
    cfg_lsb_first_i = 1'b0;
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < 2; s++)
        for (int n = 1; n <= 9; n++) begin
          cfg_swap_i = s[0];
          tick(2);
          run(n, f, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
        end

    // ignored fields set
    cfg_swap_i = 1'b1;
    tick(2);
    run(7, 1, 1'b1, 1'b1, 1'b1, 1'b0, "R11");
    cfg_four_wire_i = 1'b0;
    tick(2);
    run(5, 2, 1'b0, 1'b1, 1'b1, 1'b0, "R11");

    // no completion request
    run(3, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");

    // source stall mid-transfer
    cfg_four_wire_i = 1'b1;
    tick(2);
    run(10, 2, 1'b1, 1'b1, 1'b0, 1'b1, "R10");

    // receive-direction descriptor is dropped
    clear_mon();
    q.push_back(32'h6000_0003);
    tick(60);
    chk(q.size() == 0, "R2 rx descriptor consumed", 32'(q.size()), 0);
    chk(cs_fall_cnt == 0, "R2 no select activity", 32'(cs_fall_cnt), 0);
    chk(done_cnt == 0, "R2 no completion", 32'(done_cnt), 0);
    run(4, 0, 1'b1, 1'b1, 1'b0, 1'b0, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule